// File: doc/BRIEF.md
# Data Bus Return Sequencer

This block runs one node's side of a data return on a shared, pipelined system data bus. The local storage offers a transfer: two data words plus a flag that marks it as a control/status (CSR) access rather than a memory read. When the bus turn is granted, the block takes the words and raises the send-data strobe for one clock. It then waits for the stall line to clear and samples the snoop responses (shared, dirty) in the first clock without a stall. Three clocks later it runs two bus data cycles. Each data cycle is three clocks long: two clocks of driven data, then one dead clock with the output enable low.

If another node stalls the bus with its hold line, the block keeps its send strobe up until the stall ends, so that its request is seen afterwards. On a memory read that a snooping CPU reports as dirty, that CPU supplies the data. This node still counts out both data cycles to stay in step with the bus, but it never enables its drivers. CSR transfers use the same timing and disregard the snoop lines. When the last dead clock has passed, the block reports completion to local storage with a single-clock pulse.

Top module: `dbus_return_seq`

## Requirements
- R1: A bus data cycle is three clocks. The output enable is high in the first two and low in the third. A transfer has exactly two such data cycles back to back.
- R2: When `req_valid` and `req_ready` are both high at a clock edge, the transfer is accepted and `bus_send` is high for the following clock. `req_ready` is high only while the block is idle and `turn_grant` is high.
- R3: If `bus_hold` is high in the clock after the first send clock, `bus_send` is low in that clock. `bus_send` is then high in every clock from the next one up to and including the first clock in which `bus_hold` is low (the no-hold clock). With no hold, `bus_send` is high for that single first clock only.
- R4: The first driven data clock comes three clocks after the no-hold clock. The no-hold clock is the clock after the send clock when there is no hold.
- R5: On a memory read (`req_csr`=0), `bus_dirty` high in the no-hold clock keeps `bus_oe` low for the whole transfer and sets `done_yield`=1. The snoop lines are taken only in the no-hold clock and ignored in all other clocks.
- R6: On a CSR transfer (`req_csr`=1), `bus_dirty` and `bus_shared` are ignored: the data is driven, and `done_yield` and `done_shared` are both 0.
- R7: On a memory read, `done_shared` equals `bus_shared` as sampled in the no-hold clock.
- R8: `req_done` is high for exactly one clock, the clock after the second dead clock. The block is idle in the clock after that. `done_yield` and `done_shared` are valid while `req_done` is high.
- R9: `bus_data` carries `req_word0` in the first data cycle and `req_word1` in the second, both as captured at acceptance. It is all zeros whenever `bus_oe` is low.
- R10: While `turn_grant` is low, no transfer is accepted and `bus_send` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| turn_grant | input | 1 | It is this node's turn on the data bus |
| req_valid | input | 1 | Local storage has a transfer ready |
| req_ready | output | 1 | Block is idle and the turn is granted |
| req_csr | input | 1 | Transfer is a CSR access (snoop lines ignored) |
| req_word0 | input | DATA_W | Data for the first bus data cycle |
| req_word1 | input | DATA_W | Data for the second bus data cycle |
| req_done | output | 1 | One-clock completion pulse |
| done_yield | output | 1 | A dirty owner supplied the data (valid with req_done) |
| done_shared | output | 1 | Block was reported shared (valid with req_done) |
| bus_send | output | 1 | Send-data strobe to the bus |
| bus_hold | input | 1 | Bus stall line from other nodes |
| bus_shared | input | 1 | Snoop response: block is shared |
| bus_dirty | input | 1 | Snoop response: block is dirty in a CPU cache |
| bus_oe | output | 1 | Data bus output enable |
| bus_data | output | DATA_W | Data bus value, zero when not driven |

## Verification
Transfers are run with zero to three two-clock hold periods. Comparing these cases checks that the send strobe stretches exactly to the no-hold clock and that data launch moves with it, rather than being fixed from the send clock. The snoop lines carry random values in every clock except the no-hold clock. An early or late sample therefore shows up as a wrong drive decision or a wrong completion flag. Memory reads and CSR transfers are run with the same dirty and shared settings to separate yielding from ignoring. Random data words in the two data cycles show whether the words have been swapped or left undriven.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_SEND         = 3'd1,
    ST_WAIT_RESP    = 3'd2,
    ST_HOLD_WAIT    = 3'd3,
    ST_LAUNCH_DELAY = 3'd4,
    ST_DATA0        = 3'd5,
    ST_DATA1        = 3'd6,
    ST_DONE         = 3'd7
  } drs_state_e;

endpackage

// File: rtl/drs_phase_ctr.sv
// Free-running position counter inside a state; restarts on each state change.
module drs_phase_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/drs_snoop_cap.sv
// Captures the snoop verdict in the no-hold clock; CSR transfers mask it.
module drs_snoop_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic csr,
  input  logic shared_in,
  input  logic dirty_in,
  output logic yield,
  output logic shared_q
);

  logic yield_d, shared_d;

  always_comb begin
    yield_d  = yield;
    shared_d = shared_q;
    if (take) begin
      yield_d  = dirty_in  & ~csr;
      shared_d = shared_in & ~csr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yield    <= 1'b0;
      shared_q <= 1'b0;
    end else begin
      yield    <= yield_d;
      shared_q <= shared_d;
    end
  end

endmodule

// File: rtl/drs_beat_mux.sv
// Holds the two words of a transfer and places one on the bus when driving.
module drs_beat_mux #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word0,
  input  logic [DATA_W-1:0] word1,
  input  logic              drive,
  input  logic              sel_second,
  output logic [DATA_W-1:0] bus_data
);

  logic [DATA_W-1:0] w0_q, w1_q, w0_d, w1_d;

  always_comb begin
    w0_d = load ? word0 : w0_q;
    w1_d = load ? word1 : w1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      w1_q <= '0;
    end else begin
      w0_q <= w0_d;
      w1_q <= w1_d;
    end
  end

  always_comb begin
    if (!drive)          bus_data = '0;
    else if (sel_second) bus_data = w1_q;
    else                 bus_data = w0_q;
  end

endmodule

// File: rtl/dbus_return_seq.sv
module dbus_return_seq #(
  parameter int DATA_W     = 256,
  parameter int LAUNCH_GAP = 2,   // clocks between the no-hold clock and first data clock, exclusive
  parameter int SLOT_CLKS  = 3,   // clocks per bus data cycle
  parameter int DRIVE_CLKS = 2    // driven clocks per bus data cycle
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              turn_grant,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_csr,
  input  logic [DATA_W-1:0] req_word0,
  input  logic [DATA_W-1:0] req_word1,
  output logic              req_done,
  output logic              done_yield,
  output logic              done_shared,
  output logic              bus_send,
  input  logic              bus_hold,
  input  logic              bus_shared,
  input  logic              bus_dirty,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data
);
  import drs_pkg::*;

  localparam int CNT_W = $clog2(SLOT_CLKS + LAUNCH_GAP + 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(LAUNCH_GAP - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CLKS - 1);
  localparam logic [CNT_W-1:0] DRIVE_N   = CNT_W'(DRIVE_CLKS);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  drs_state_e       state_q, state_d;
  logic [CNT_W-1:0] pos;
  logic             accept, snoop_take, csr_q, csr_d;
  logic             snoop_yield, snoop_shared, drive_slot;

  assign req_ready  = (state_q == ST_IDLE) && turn_grant;
  assign accept     = req_valid && req_ready;
  assign snoop_take = ((state_q == ST_WAIT_RESP) || (state_q == ST_HOLD_WAIT)) && !bus_hold;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:         if (accept)           state_d = ST_SEND;
      ST_SEND:                               state_d = ST_WAIT_RESP;
      ST_WAIT_RESP:    if (bus_hold)         state_d = ST_HOLD_WAIT;
                       else                  state_d = ST_LAUNCH_DELAY;
      ST_HOLD_WAIT:    if (!bus_hold)        state_d = ST_LAUNCH_DELAY;
      ST_LAUNCH_DELAY: if (pos == GAP_LAST)  state_d = ST_DATA0;
      ST_DATA0:        if (pos == SLOT_LAST) state_d = ST_DATA1;
      ST_DATA1:        if (pos == SLOT_LAST) state_d = ST_DONE;
      ST_DONE:                               state_d = ST_IDLE;
      default:                               state_d = ST_IDLE;
    endcase
  end

  always_comb csr_d = accept ? req_csr : csr_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      csr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      csr_q   <= csr_d;
    end
  end

  drs_phase_ctr #(.CNT_W(CNT_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (state_d != state_q),
    .cnt     (pos)
  );

  drs_snoop_cap u_snoop (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (snoop_take),
    .csr       (csr_q),
    .shared_in (bus_shared),
    .dirty_in  (bus_dirty),
    .yield     (snoop_yield),
    .shared_q  (snoop_shared)
  );

  // outputs decoded from registered state only
  assign drive_slot = ((state_q == ST_DATA0) || (state_q == ST_DATA1)) && (pos < DRIVE_N);
  assign bus_oe     = drive_slot && !snoop_yield;
  assign bus_send   = (state_q == ST_SEND) || (state_q == ST_HOLD_WAIT);
  assign req_done   = (state_q == ST_DONE);
  assign done_yield  = snoop_yield;
  assign done_shared = snoop_shared;

  drs_beat_mux #(.DATA_W(DATA_W)) u_beats (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept),
    .word0      (req_word0),
    .word1      (req_word1),
    .drive      (bus_oe),
    .sel_second (state_q == ST_DATA1),
    .bus_data   (bus_data)
  );

endmodule

// File: rtl/drs_chk.sv
module drs_chk (
  input logic                clk,
  input logic                rst_n,
  input drs_pkg::drs_state_e st,
  input logic                bus_send,
  input logic                bus_hold,
  input logic                bus_oe,
  input logic                req_done,
  input logic                yield
);
  import drs_pkg::*;

  // R1
  dead_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_oe, 2) && $past(bus_oe)) |-> !bus_oe);

  // R2
  send_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_send);

  // R3
  hold_keeps_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD_WAIT && bus_hold) |=> bus_send);

  // R5
  yield_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield |-> !bus_oe);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> (!req_done && st == ST_IDLE));

  // R4
  launch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAUNCH_DELAY) |-> (!bus_oe && !bus_send));

endmodule

bind dbus_return_seq drs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .st       (state_q),
  .bus_send (bus_send),
  .bus_hold (bus_hold),
  .bus_oe   (bus_oe),
  .req_done (req_done),
  .yield    (snoop_yield)
);

// File: tb/tb_dbus_return_seq.sv
module tb_dbus_return_seq;
  localparam int DW = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, turn_grant, req_valid, req_ready, req_csr, req_done;
  logic done_yield, done_shared, bus_send, bus_hold, bus_shared, bus_dirty, bus_oe;
  logic [DW-1:0] req_word0, req_word1, bus_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  dbus_return_seq #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .turn_grant(turn_grant), .req_valid(req_valid),
    .req_ready(req_ready), .req_csr(req_csr), .req_word0(req_word0),
    .req_word1(req_word1), .req_done(req_done), .done_yield(done_yield),
    .done_shared(done_shared), .bus_send(bus_send), .bus_hold(bus_hold),
    .bus_shared(bus_shared), .bus_dirty(bus_dirty), .bus_oe(bus_oe),
    .bus_data(bus_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rand_word();
    logic [DW-1:0] w;
    for (int i = 0; i < DW / 32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  // Expected bus behaviour at clock k after acceptance (k=0 is the send clock)
  function automatic int no_hold_clk(input int h);
    return (h == 0) ? 1 : 2 * h + 1;
  endfunction
  function automatic bit exp_send(input int k, input int h);
    return (k == 0) || (h > 0 && k >= 2 && k <= no_hold_clk(h));
  endfunction
  function automatic bit exp_slot(input int k, input int h);
    int n = no_hold_clk(h);
    return (k == n + 3) || (k == n + 4) || (k == n + 6) || (k == n + 7);
  endfunction

  task automatic run_txn(input int h, input bit csr, input bit dirty, input bit shared);
    logic [DW-1:0] w0, w1, exp_data;
    int n;
    bit yield_e, drive_e;
    n  = no_hold_clk(h);
    w0 = rand_word();
    w1 = rand_word();
    yield_e = dirty && !csr;
    @(negedge clk);
    turn_grant = 1'b1;
    req_valid  = 1'b1;
    req_csr    = csr;
    req_word0  = w0;
    req_word1  = w1;
    bus_hold   = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R2", "ready before accept", DW'(req_ready), DW'(1));
    for (int k = 0; k <= n + 10; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_word0 = rand_word();
      req_word1 = rand_word();
      req_csr   = $urandom_range(0, 1);
      bus_hold  = (k >= 1 && k <= 2 * h);
      bus_shared = (k == n) ? shared : 1'($urandom_range(0, 1));
      bus_dirty  = (k == n) ? dirty  : 1'($urandom_range(0, 1));
      #1;
      chk(bus_send == exp_send(k, h), (k == 0) ? "R2" : "R3",
          $sformatf("send k=%0d h=%0d", k, h), DW'(bus_send), DW'(exp_send(k, h)));
      drive_e = exp_slot(k, h) && !yield_e;
      chk(bus_oe == drive_e, yield_e ? "R5" : (csr ? "R6" : "R4"),
          $sformatf("oe k=%0d h=%0d", k, h), DW'(bus_oe), DW'(drive_e));
      if (exp_slot(k, h) && !yield_e && k >= n + 3 && k <= n + 4 && !bus_oe)
        chk(1'b0, "R1", "first data cycle not driven", DW'(bus_oe), DW'(1));
      exp_data = drive_e ? ((k <= n + 4) ? w0 : w1) : '0;
      chk(bus_data == exp_data, "R9", $sformatf("data k=%0d", k), bus_data, exp_data);
      chk(req_done == (k == n + 9), "R8", $sformatf("done k=%0d", k),
          DW'(req_done), DW'(k == n + 9));
      if (k == n + 9) begin
        chk(done_yield == yield_e, csr ? "R6" : "R5", "done_yield",
            DW'(done_yield), DW'(yield_e));
        chk(done_shared == (shared && !csr), csr ? "R6" : "R7", "done_shared",
            DW'(done_shared), DW'(shared && !csr));
      end
      if (k == n + 10)
        chk(req_ready == 1'b1, "R8", "idle after done", DW'(req_ready), DW'(1));
      else
        chk(req_ready == 1'b0, "R2", $sformatf("ready busy k=%0d", k), DW'(req_ready), DW'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    rst_n = 1'b0; turn_grant = 1'b0; req_valid = 1'b0; req_csr = 1'b0;
    req_word0 = '0; req_word1 = '0; bus_hold = 1'b0; bus_shared = 1'b0; bus_dirty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(bus_send == 1'b0 && bus_oe == 1'b0 && req_done == 1'b0, "R8", "reset outputs",
        DW'({bus_send, bus_oe, req_done}), DW'(0));
    chk(bus_data == '0, "R9", "reset data", bus_data, '0);

    // R10: request without the turn
    req_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1;
      chk(bus_send == 1'b0, "R10", "send without grant", DW'(bus_send), DW'(0));
      chk(req_ready == 1'b0, "R10", "ready without grant", DW'(req_ready), DW'(0));
    end
    req_valid = 1'b0;

    // directed corners
    run_txn(0, 1'b0, 1'b0, 1'b0);
    run_txn(1, 1'b0, 1'b1, 1'b0);
    run_txn(2, 1'b1, 1'b1, 1'b1);
    run_txn(3, 1'b0, 1'b0, 1'b1);
    run_txn(0, 1'b1, 1'b0, 1'b1);
    run_txn(0, 1'b0, 1'b1, 1'b1);

    // random mix
    for (int t = 0; t < 40; t++)
      run_txn($urandom_range(0, 3), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule